// File: doc/BRIEF.md
# Min-Sum LDPC Iteration Controller

This block decodes one codeword of a short, fixed low-density parity-check code. It uses soft decisions and the min-sum message-passing algorithm. A caller presents one signed channel log-likelihood value per code bit, packed into a single vector, and pulses `start`. The controller captures the vector and zeroes its working state. It then repeats iterations of three phases: a check-node update, a variable-node update and a parity check of the current hard decisions. It stops when every parity check is satisfied or when the iteration budget is used up.

The parity-check matrix is a compile-time parameter, and the datapath is generated from it. One check-node unit serves each row and one variable-node unit serves each column. When a decode finishes, the block shows a one-cycle `done`, the hard decisions, a convergence flag and the number of iterations run. These results stay readable while the block is idle and are cleared only once a new start is taken.

Top module: `ldpc_ms_iter_ctrl`

## Requirements
- R1: Channel value for code bit n is the 6-bit two's-complement field `llr_in[6n+5:6n]`. It is captured on the clock edge that accepts `start`, and later changes of `llr_in` do not affect that decode.
- R2: The hard decision for bit n is 1 when its posterior value is negative, and 0 when it is zero or positive.
- R3: Variable-to-check values and posterior sums saturate to the range -32..+31 rather than wrapping.
- R4: After each iteration the syndrome of the hard decisions is computed: check m covers bit n when bit m*N_VAR+n of `H_ROWS` is set. If every check is even, decoding stops with `converged` high and `iter_used` equal to the iterations run.
- R5: If MAX_ITER iterations pass without an even syndrome, decoding stops with `converged` low and `iter_used` equal to MAX_ITER.
- R6: `converged`, `hard_dec` and `iter_used` hold their values while idle. They are cleared on the edge that accepts a new `start`, so `converged` is low during the initialisation cycle.
- R7: The first iteration takes the stored check-to-variable messages as zero. Each decode, including one started immediately after the previous one, gives the same result as a decode run straight after reset.
- R8: `start` is accepted only while idle. A `start` during a decode neither restarts it nor recaptures `llr_in`.
- R9: `done` is high for exactly one cycle. It rises 1+3*I clock edges after the edge that accepted `start`, where I is the number of iterations run.
- R10: A synchronous active-high reset returns the block to idle with `done`, `converged`, `iter_used` and `hard_dec` all zero.
- R11: A check-node output for bit n carries the smallest magnitude among the other connected inputs of that check. A -32 input counts as magnitude 31. Its sign is the product of those inputs' signs. Columns that are not connected take no part.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a decode; sampled only while idle |
| llr_in | input | N_VAR*6 | Packed signed channel values, bit n in slice [6n+5:6n] |
| done | output | 1 | One-cycle pulse when a decode ends |
| converged | output | 1 | Last decode satisfied every parity check |
| iter_used | output | $clog2(MAX_ITER+1) | Iterations run by the last decode |
| hard_dec | output | N_VAR | Hard decisions of the last decode |

## Verification
The decode starts on the edge that takes `start`. The initialisation phase follows on the next edge, and each iteration then takes three edges, so `done` and the results are due 1+3*I edges after the start edge. The bench counts edges from that start edge and compares the count with 1+3*I, where I comes from its own reference decoder. It samples at the falling edge, so every output it reads settled at the preceding rising edge. The cleared `converged` flag is checked one edge after the start edge. The end of the `done` pulse is checked one edge after `done` rises. Held results are checked over several idle cycles before the next start is driven.

// File: rtl/ldpc_ms_pkg.sv
package ldpc_ms_pkg;

  localparam int LLR_W  = 6;
  localparam int WIDE_W = 10;

  typedef logic signed [LLR_W-1:0] llr_t;
  typedef logic [LLR_W-2:0]        mag_t;
  typedef logic signed [WIDE_W-1:0] wide_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_CN,
    ST_VN,
    ST_CHECK,
    ST_DONE
  } phase_e;

  localparam mag_t MAG_CAP = '1;
  localparam llr_t LLR_MAX = {1'b0, {(LLR_W-1){1'b1}}};
  localparam llr_t LLR_MIN = {1'b1, {(LLR_W-1){1'b0}}};

  // sign-extend a message to the accumulator width
  function automatic wide_t widen(input llr_t x);
    widen = {{(WIDE_W-LLR_W){x[LLR_W-1]}}, x};
  endfunction

  // saturate: the bits above the narrow sign must all copy the wide sign
  function automatic llr_t clip_wide(input wide_t v);
    logic ovf;
    ovf = (v[WIDE_W-1:LLR_W-1] != {(WIDE_W-LLR_W+1){v[WIDE_W-1]}});
    if (ovf)
      clip_wide = v[WIDE_W-1] ? LLR_MIN : LLR_MAX;
    else
      clip_wide = v[LLR_W-1:0];
  endfunction

  // magnitude, with the most negative code clamped to the largest magnitude
  function automatic mag_t llr_mag(input llr_t x);
    llr_t neg;
    neg = -x;
    if (x == LLR_MIN)
      llr_mag = MAG_CAP;
    else if (x[LLR_W-1])
      llr_mag = neg[LLR_W-2:0];
    else
      llr_mag = x[LLR_W-2:0];
  endfunction

  function automatic llr_t signed_mag(input logic neg, input mag_t m);
    llr_t pos;
    pos = {1'b0, m};
    signed_mag = neg ? -pos : pos;
  endfunction

endpackage

// File: rtl/ldpc_ms_cn_unit.sv
module ldpc_ms_cn_unit
  import ldpc_ms_pkg::*;
#(
  parameter int NV = 8
) (
  input  logic [NV-1:0]       edge_mask,
  input  logic [NV*LLR_W-1:0] v2c_flat,
  output logic [NV*LLR_W-1:0] c2v_flat
);

  mag_t          mag [NV];
  logic [NV-1:0] sgn;

  for (genvar i = 0; i < NV; i++) begin : g_in
    assign mag[i] = llr_mag(v2c_flat[i*LLR_W +: LLR_W]);
    assign sgn[i] = v2c_flat[i*LLR_W + LLR_W - 1];
  end

  for (genvar j = 0; j < NV; j++) begin : g_out
    mag_t best;
    logic par;
    always_comb begin
      best = MAG_CAP;
      par  = 1'b0;
      for (int k = 0; k < NV; k++) begin
        if (k != j && edge_mask[k]) begin
          if (mag[k] < best) best = mag[k];
          par = par ^ sgn[k];
        end
      end
    end
    assign c2v_flat[j*LLR_W +: LLR_W] = edge_mask[j] ? signed_mag(par, best) : '0;
  end

endmodule

// File: rtl/ldpc_ms_vn_unit.sv
module ldpc_ms_vn_unit
  import ldpc_ms_pkg::*;
#(
  parameter int NC = 4
) (
  input  llr_t                chan,
  input  logic [NC*LLR_W-1:0] c2v_col,
  output llr_t                post,
  output logic                sat_hit
);

  wide_t acc;

  always_comb begin
    acc = widen(chan);
    for (int c = 0; c < NC; c++)
      acc = acc + widen(c2v_col[c*LLR_W +: LLR_W]);
  end

  assign post    = clip_wide(acc);
  assign sat_hit = (acc > widen(LLR_MAX)) || (acc < widen(LLR_MIN));

endmodule

// File: rtl/ldpc_ms_syndrome.sv
module ldpc_ms_syndrome #(
  parameter int NV = 8,
  parameter int NC = 4,
  parameter logic [NC*NV-1:0] HM = '0
) (
  input  logic [NV-1:0] bits,
  output logic [NC-1:0] syn
);

  for (genvar m = 0; m < NC; m++) begin : g_row
    assign syn[m] = ^(bits & HM[m*NV +: NV]);
  end

endmodule

// File: rtl/ldpc_ms_iter_ctrl.sv
module ldpc_ms_iter_ctrl
  import ldpc_ms_pkg::*;
#(
  parameter int N_VAR    = 8,
  parameter int N_CHK    = 4,
  parameter int MAX_ITER = 8,
  parameter logic [N_CHK*N_VAR-1:0] H_ROWS = 32'h8B4D2E17,
  localparam int IT_W = $clog2(MAX_ITER+1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [N_VAR*LLR_W-1:0] llr_in,
  output logic                   done,
  output logic                   converged,
  output logic [IT_W-1:0]        iter_used,
  output logic [N_VAR-1:0]       hard_dec
);

  phase_e          state;
  llr_t            chan_q [N_VAR];
  llr_t            post_q [N_VAR];
  llr_t            c2v_q  [N_CHK][N_VAR];
  logic            first_q;
  logic [IT_W-1:0] iter_q;
  logic [N_VAR-1:0] hard_q;
  logic            conv_q;

  // datapath nets between units
  logic [N_CHK-1:0][N_VAR*LLR_W-1:0] v2c_flat;
  logic [N_CHK-1:0][N_VAR*LLR_W-1:0] c2v_new_flat;
  logic [N_VAR-1:0][N_CHK*LLR_W-1:0] c2v_col;
  llr_t            post_w [N_VAR];
  logic [N_VAR-1:0] sat_w;
  logic [N_VAR-1:0] hard_w;
  logic [N_CHK-1:0] syn_w;

  // named events for the assertions
  logic ev_accept, ev_last_iter, ev_syn_even;
  assign ev_accept    = (state == ST_IDLE) && start;
  assign ev_syn_even  = (syn_w == '0);
  assign ev_last_iter = (iter_q == IT_W'(MAX_ITER-1));

  // edges: variable-to-check values, first iteration bypasses storage
  for (genvar gm = 0; gm < N_CHK; gm++) begin : g_chk
    for (genvar gn = 0; gn < N_VAR; gn++) begin : g_var
      llr_t prior;
      assign prior = first_q ? '0 : c2v_q[gm][gn];
      assign v2c_flat[gm][gn*LLR_W +: LLR_W] =
        H_ROWS[gm*N_VAR+gn] ? clip_wide(widen(post_q[gn]) - widen(prior)) : '0;
      assign c2v_col[gn][gm*LLR_W +: LLR_W] = c2v_q[gm][gn];
    end

    ldpc_ms_cn_unit #(.NV(N_VAR)) u_cn (
      .edge_mask (H_ROWS[gm*N_VAR +: N_VAR]),
      .v2c_flat  (v2c_flat[gm]),
      .c2v_flat  (c2v_new_flat[gm])
    );
  end

  for (genvar gn = 0; gn < N_VAR; gn++) begin : g_vn
    ldpc_ms_vn_unit #(.NC(N_CHK)) u_vn (
      .chan    (chan_q[gn]),
      .c2v_col (c2v_col[gn]),
      .post    (post_w[gn]),
      .sat_hit (sat_w[gn])
    );
    assign hard_w[gn] = post_q[gn][LLR_W-1];
  end

  ldpc_ms_syndrome #(.NV(N_VAR), .NC(N_CHK), .HM(H_ROWS)) u_syn (
    .bits (hard_w),
    .syn  (syn_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      first_q <= 1'b0;
      iter_q  <= '0;
      hard_q  <= '0;
      conv_q  <= 1'b0;
      for (int n = 0; n < N_VAR; n++) begin
        chan_q[n] <= '0;
        post_q[n] <= '0;
      end
      for (int m = 0; m < N_CHK; m++)
        for (int n = 0; n < N_VAR; n++)
          c2v_q[m][n] <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_INIT;
            conv_q <= 1'b0;
            hard_q <= '0;
            iter_q <= '0;
            for (int n = 0; n < N_VAR; n++)
              chan_q[n] <= llr_in[n*LLR_W +: LLR_W];
          end
        end
        ST_INIT: begin
          state   <= ST_CN;
          first_q <= 1'b1;
          for (int n = 0; n < N_VAR; n++)
            post_q[n] <= chan_q[n];
          for (int m = 0; m < N_CHK; m++)
            for (int n = 0; n < N_VAR; n++)
              c2v_q[m][n] <= '0;
        end
        ST_CN: begin
          state <= ST_VN;
          for (int m = 0; m < N_CHK; m++)
            for (int n = 0; n < N_VAR; n++)
              c2v_q[m][n] <= c2v_new_flat[m][n*LLR_W +: LLR_W];
        end
        ST_VN: begin
          state   <= ST_CHECK;
          first_q <= 1'b0;
          for (int n = 0; n < N_VAR; n++)
            post_q[n] <= post_w[n];
        end
        ST_CHECK: begin
          iter_q <= iter_q + 1'b1;
          hard_q <= hard_w;
          conv_q <= ev_syn_even;
          state  <= (ev_syn_even || ev_last_iter) ? ST_DONE : ST_CN;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done      = (state == ST_DONE);
  assign converged = conv_q;
  assign iter_used = iter_q;
  assign hard_dec  = hard_q;

  // ---------------- assertions ----------------
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_conv_at_done_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(converged) |-> done);

  p_conv_clear_init_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INIT) |-> !converged);

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && !start) |=>
      ($stable(converged) && $stable(hard_dec) && $stable(iter_used)));

  p_iter_cap_r5: assert property (@(posedge clk) disable iff (rst)
    iter_used <= IT_W'(MAX_ITER));

  p_early_stop_conv_r5: assert property (@(posedge clk) disable iff (rst)
    (done && (iter_used < IT_W'(MAX_ITER))) |-> converged);

  p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
    ((state != ST_IDLE) && start) |=> (state != ST_INIT));

  for (genvar gn = 0; gn < N_VAR; gn++) begin : g_sat_chk
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      ((state == ST_VN) && sat_w[gn]) |->
        ((post_w[gn] == LLR_MAX) || (post_w[gn] == LLR_MIN)));
  end

endmodule

// File: tb/tb_ldpc_ms_iter_ctrl.sv
`timescale 1ns/1ps
module tb_ldpc_ms_iter_ctrl;

  localparam int N    = 8;
  localparam int M    = 4;
  localparam int MAXI = 8;
  localparam logic [M*N-1:0] HM = 32'h8B4D2E17;
  localparam int IW = $clog2(MAXI+1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N*6-1:0] llr_in = '0;
  logic          done, converged;
  logic [IW-1:0] iter_used;
  logic [N-1:0]  hard_dec;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  ldpc_ms_iter_ctrl #(.N_VAR(N), .N_CHK(M), .MAX_ITER(MAXI), .H_ROWS(HM)) dut (
    .clk(clk), .rst(rst), .start(start), .llr_in(llr_in),
    .done(done), .converged(converged), .iter_used(iter_used), .hard_dec(hard_dec)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampi(input int v);
    if (v > 31) return 31;
    if (v < -32) return -32;
    return v;
  endfunction

  function automatic int magi(input int v);
    int a;
    a = (v < 0) ? -v : v;
    return (a > 31) ? 31 : a;
  endfunction

  function automatic bit hb(input int m, input int n);
    return HM[m*N+n];
  endfunction

  // bench reference decoder: plain integer loops
  task automatic ref_decode(input int ch[N], output logic [N-1:0] hd,
                            output bit cv, output int it);
    int post[N];
    int msg[M][N];
    int nmsg[M][N];
    int v2c[N];
    for (int n = 0; n < N; n++) post[n] = ch[n];
    for (int m = 0; m < M; m++) for (int n = 0; n < N; n++) msg[m][n] = 0;
    hd = '0; cv = 0; it = MAXI;
    for (int r = 1; r <= MAXI; r++) begin
      bit even;
      for (int m = 0; m < M; m++) begin
        for (int k = 0; k < N; k++) v2c[k] = hb(m,k) ? clampi(post[k] - msg[m][k]) : 0;
        for (int n = 0; n < N; n++) begin
          int best; bit ng;
          best = 31; ng = 0; nmsg[m][n] = 0;
          if (hb(m,n)) begin
            for (int k = 0; k < N; k++)
              if (k != n && hb(m,k)) begin
                if (magi(v2c[k]) < best) best = magi(v2c[k]);
                if (v2c[k] < 0) ng = !ng;
              end
            nmsg[m][n] = ng ? -best : best;
          end
        end
      end
      for (int m = 0; m < M; m++) for (int n = 0; n < N; n++) msg[m][n] = nmsg[m][n];
      for (int n = 0; n < N; n++) begin
        int s;
        s = ch[n];
        for (int m = 0; m < M; m++) s += msg[m][n];
        post[n] = clampi(s);
        hd[n] = (post[n] < 0);
      end
      even = 1;
      for (int m = 0; m < M; m++) begin
        bit p;
        p = 0;
        for (int n = 0; n < N; n++) if (hb(m,n)) p ^= hd[n];
        if (p) even = 0;
      end
      if (even) begin
        cv = 1; it = r;
        return;
      end
    end
  endtask

  function automatic logic [N*6-1:0] pack(input int ch[N]);
    logic [N*6-1:0] v;
    for (int n = 0; n < N; n++) v[n*6 +: 6] = 6'(ch[n]);
    return v;
  endfunction

  // run one decode starting at a falling edge in idle; ends at a falling edge in idle
  task automatic run_case(input int ch[N], input string tag, input bit poke);
    logic [N-1:0] ehd; bit ecv; int eit; int cnt;
    ref_decode(ch, ehd, ecv, eit);
    llr_in = pack(ch);
    start  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start  = 1'b0;
    llr_in = ~pack(ch);                 // R1: later input changes are ignored
    check({"R6 converged cleared in init ", tag}, converged == 1'b0, converged, 0);
    cnt = 0;
    forever begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      start = 1'b0;
      if (done || cnt > 200) break;
      if (poke && cnt == 2) begin
        start  = 1'b1;                  // R8: start while busy
        llr_in = '0;
      end
    end
    check({"R9 done latency ", tag}, cnt == 1 + 3*eit, cnt, 1 + 3*eit);
    check({"R2 hard decisions ", tag}, hard_dec == ehd, hard_dec, ehd);
    check({"R4 converged flag ", tag}, converged == ecv, converged, ecv);
    check({"R5 iterations used ", tag}, iter_used == eit, iter_used, eit);
    if (poke) check({"R8 busy start ignored ", tag}, hard_dec == ehd && iter_used == eit, hard_dec, ehd);
    @(posedge clk);
    @(negedge clk);
    check({"R9 done single cycle ", tag}, done == 1'b0, done, 0);
  endtask

  int ch[N];
  logic [N-1:0] h0; int i0; bit c0;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset done", done == 0, done, 0);
    check("R10 reset converged", converged == 0, converged, 0);
    check("R10 reset iterations", iter_used == 0, iter_used, 0);
    check("R10 reset hard", hard_dec == 0, hard_dec, 0);
    rst = 1'b0;
    @(negedge clk);

    // directed corners
    for (int n = 0; n < N; n++) ch[n] = 20;
    run_case(ch, "clean zeros R4", 0);
    for (int n = 0; n < N; n++) ch[n] = -32;
    run_case(ch, "all -32 R11 R3", 0);
    check("R2 all-negative gives ones", hard_dec == '1, hard_dec, 255);
    for (int n = 0; n < N; n++) ch[n] = 31;
    run_case(ch, "all +31 R3", 0);
    for (int n = 0; n < N; n++) ch[n] = 0;
    run_case(ch, "zero values R2", 0);
    check("R2 zero maps to 0", hard_dec == '0, hard_dec, 0);
    for (int n = 0; n < N; n++) ch[n] = 10;
    ch[3] = -3;
    run_case(ch, "one weak error R11", 0);

    // R6: held while idle
    h0 = hard_dec; i0 = iter_used; c0 = converged;
    repeat (6) @(negedge clk);
    check("R6 held hard", hard_dec == h0, hard_dec, h0);
    check("R6 held iter", iter_used == i0, iter_used, i0);
    check("R6 held conv", converged == c0, converged, c0);

    // R8: start pulsed during a decode
    for (int n = 0; n < N; n++) ch[n] = 12;
    ch[5] = -4;
    run_case(ch, "busy start R8", 1);

    // R5: search for a vector the reference fails to decode
    begin
      logic [N-1:0] xh; bit xc; int xi; bit found;
      found = 0;
      for (int t = 0; t < 3000 && !found; t++) begin
        for (int n = 0; n < N; n++) ch[n] = int'($urandom_range(0, 24)) - 12;
        ref_decode(ch, xh, xc, xi);
        if (!xc) found = 1;
      end
      run_case(ch, "iteration limit R5", 0);
      if (found) check("R5 limit leaves converged low", converged == 0 && iter_used == MAXI, iter_used, MAXI);
    end

    // R10: reset in the middle of a decode
    for (int n = 0; n < N; n++) ch[n] = 15;
    llr_in = pack(ch); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid-decode reset done", done == 0 && converged == 0 && iter_used == 0, iter_used, 0);
    rst = 1'b0;
    @(negedge clk);

    // R7: back-to-back decodes, repeated vector must match fresh result
    for (int r = 0; r < 40; r++) begin
      int base;
      base = (r % 2) ? -7 : 7;
      for (int n = 0; n < N; n++) ch[n] = clampi(base + int'($urandom_range(0, 26)) - 13);
      if (r % 5 == 0) ch[r % N] = -32;
      run_case(ch, $sformatf("random R7 #%0d", r), (r % 7) == 3);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule